// File: doc/BRIEF.md
# Secondary-Core Release Table

The block is a small memory-mapped table that parks the secondary cores of a multicore cluster until software lets each one go. The table has one 32-byte record per core slot. A single request channel reads and writes the records in 1, 2 or 4 byte units, in big-endian byte order. Each record holds a 64-bit start address whose bit 0 means "keep waiting", a 64-bit argument, the core's processor identifier and padding. Per-record layout, counted in bytes from the record base: start address at 0..7, argument at 8..15, a spare word at 16..19, processor identifier at 20..23, and spare bytes at 24..31.

Only writes to records of present secondary cores are accepted. If such a write leaves the record's start-address bit 0 at zero, the block raises a one-cycle release strobe for that core. In the same cycle it drives the start offset inside a 64 MiB window, the 64 MiB-aligned window base, the argument and the window size. It also stamps the core's real processor identifier into the record. The wake-up of the core and the programming of its address translation belong to the consumer of the strobe.

The request channel is valid/ready. `req_ready` is held high, so every request with `req_valid` high is taken on that clock edge and there is never back-pressure. Read responses come back one cycle later on `rsp_valid` and cannot be stalled, so the requester must always accept them.

Top module: `spin_table_ctrl`

## Requirements
- R1: After reset, record i holds start address 1, argument i, processor identifier i, and zero in all other bytes.
- R2: A read taken on edge t returns its data with `rsp_valid` high after edge t+1's predecessor, that is, in the cycle that follows acceptance. `rsp_valid` is high only in that case. `rsp_rdata` holds the addressed bytes in big-endian order, zero-extended: size code 0 gives one byte, 1 gives two bytes, 2 gives four bytes.
- R3: An accepted write stores `req_wdata` big-endian. Size 0 stores bits 7:0 at the byte. Size 1 stores bits 15:8 then 7:0. Size 2 stores bits 31:24 down to 7:0. For sizes 1 and 2, the low 1 or 2 address bits are ignored, which aligns the access.
- R4: Writes to record 0 (the boot core) change nothing and never raise a release.
- R5: Writes to records with index at or above `NUM_PRESENT` change nothing and never raise a release.
- R6: When an accepted write leaves start-address bit 0 at zero, `rel_pulse` has exactly bit i high for one cycle. This is the cycle after the write, where i is the record index.
- R7: With the strobe, `rel_offset` is the start address modulo 2^`MAP_SHIFT` and `rel_base` is the address with its low `MAP_SHIFT` bits cleared. `rel_map_size` is always 2^`MAP_SHIFT` (64 MiB by default).
- R8: With the strobe, `rel_arg` equals the record's argument as it stands after the write.
- R9: A release overwrites the record's processor identifier with `PID_BASE` + i.
- R10: Every later accepted write to the record releases again while bit 0 stays zero. No release occurs once bit 0 is one.
- R11: A read with size code 3 returns zero with `rsp_err` high. A write with size code 3 is dropped.
- R12: `req_ready` is always high. `rel_offset`, `rel_base` and `rel_arg` keep their values between releases and are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | $clog2(NUM_CORES)+5 | Byte address in the table |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| req_wdata | input | 32 | Right-justified write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, zero-extended |
| rsp_err | output | 1 | Read used an invalid size |
| rel_pulse | output | NUM_CORES | One-cycle release strobe per core |
| rel_offset | output | 64 | Start offset within the window |
| rel_base | output | 64 | Window base address |
| rel_arg | output | 64 | Argument for the released core |
| rel_map_size | output | 64 | Window size in bytes |

## Verification
Every result of this block is due exactly one clock edge after the request is accepted. This covers the read response and error flag, the release strobe with its offset, base and argument, and the table update that a following read can see. The bench drives a request half a cycle before the edge, then compares the read response at the next falling edge. A per-cycle monitor one time unit after each rising edge compares the strobe and the held release values against a byte-array model. That model was updated when the request was issued, so any release that is early, late, repeated or missing shows up in a specific cycle.

// File: rtl/spin_pkg.sv
package spin_pkg;
  localparam int ENTRY_BYTES = 32;
  localparam int OFS_W       = $clog2(ENTRY_BYTES);
  localparam int ADDR_FIELD  = 0;
  localparam int ARG_FIELD   = 8;
  localparam int PID_FIELD   = 20;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  typedef logic [ENTRY_BYTES-1:0][7:0] entry_t;
endpackage

// File: rtl/spin_lane_decode.sv
module spin_lane_decode
  import spin_pkg::*;
(
  input  logic [OFS_W-1:0]       off,
  input  acc_size_e              size,
  input  logic [31:0]            wdata,
  output logic [ENTRY_BYTES-1:0] wen,
  output entry_t                 wbyte
);
  for (genvar b = 0; b < ENTRY_BYTES; b++) begin : g_lane
    localparam logic [OFS_W-1:0] BI = OFS_W'(b);
    localparam int HSH = (b % 2 == 1) ? 0 : 8;
    localparam int WSH = 8 * (3 - (b % 4));
    always_comb begin
      unique case (size)
        SZ_BYTE: begin
          wen[b]   = (BI == off);
          wbyte[b] = wdata[7:0];
        end
        SZ_HALF: begin
          wen[b]   = (BI[OFS_W-1:1] == off[OFS_W-1:1]);
          wbyte[b] = wdata[HSH +: 8];
        end
        SZ_WORD: begin
          wen[b]   = (BI[OFS_W-1:2] == off[OFS_W-1:2]);
          wbyte[b] = wdata[WSH +: 8];
        end
        default: begin
          wen[b]   = 1'b0;
          wbyte[b] = 8'h00;
        end
      endcase
    end
  end
endmodule

// File: rtl/spin_read_mux.sv
module spin_read_mux
  import spin_pkg::*;
(
  input  entry_t           ent,
  input  logic [OFS_W-1:0] off,
  input  acc_size_e        size,
  output logic [31:0]      rdata,
  output logic             bad
);
  logic [OFS_W-1:0] h0, h1, w0, w1, w2, w3;

  always_comb begin
    h0 = {off[OFS_W-1:1], 1'b0};
    h1 = {off[OFS_W-1:1], 1'b1};
    w0 = {off[OFS_W-1:2], 2'd0};
    w1 = {off[OFS_W-1:2], 2'd1};
    w2 = {off[OFS_W-1:2], 2'd2};
    w3 = {off[OFS_W-1:2], 2'd3};
    bad = 1'b0;
    unique case (size)
      SZ_BYTE: rdata = {24'h0, ent[off]};
      SZ_HALF: rdata = {16'h0, ent[h0], ent[h1]};
      SZ_WORD: rdata = {ent[w0], ent[w1], ent[w2], ent[w3]};
      default: begin
        rdata = 32'h0;
        bad   = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/spin_release_gen.sv
module spin_release_gen #(
  parameter int NUM_CORES = 32,
  parameter int MAP_SHIFT = 26,
  localparam int IDX_W = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic [IDX_W-1:0]     idx,
  input  logic [63:0]          start_addr,
  input  logic [63:0]          arg,
  output logic [NUM_CORES-1:0] pulse,
  output logic [63:0]          offset,
  output logic [63:0]          base,
  output logic [63:0]          arg_o
);
  localparam logic [63:0] WIN_MASK = (64'd1 << MAP_SHIFT) - 64'd1;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_strobe
    always_ff @(posedge clk) begin
      if (!rst_n) pulse[c] <= 1'b0;
      else        pulse[c] <= fire && (idx == IDX_W'(c));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offset <= '0;
      base   <= '0;
      arg_o  <= '0;
    end else if (fire) begin
      offset <= start_addr & WIN_MASK;
      base   <= start_addr & ~WIN_MASK;
      arg_o  <= arg;
    end
  end
endmodule

// File: rtl/spin_table_ctrl.sv
module spin_table_ctrl
  import spin_pkg::*;
#(
  parameter int          NUM_CORES   = 32,
  parameter int          NUM_PRESENT = 6,
  parameter logic [31:0] PID_BASE    = 32'h0000_0100,
  parameter int          MAP_SHIFT   = 26,
  localparam int IDX_W  = $clog2(NUM_CORES),
  localparam int ADDR_W = IDX_W + OFS_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_size,
  input  logic [31:0]          req_wdata,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_rdata,
  output logic                 rsp_err,
  output logic [NUM_CORES-1:0] rel_pulse,
  output logic [63:0]          rel_offset,
  output logic [63:0]          rel_base,
  output logic [63:0]          rel_arg,
  output logic [63:0]          rel_map_size
);
  entry_t tbl [NUM_CORES];

  logic [IDX_W-1:0]       idx;
  logic [OFS_W-1:0]       off;
  acc_size_e              size;
  entry_t                 cur, merged, nxt, wbyte;
  logic [ENTRY_BYTES-1:0] wen;
  logic [63:0]            ent_addr, ent_arg;
  logic [31:0]            pid_new, rd_data;
  logic                   rd_bad, wr_ok, fire, rd_fire;

  assign req_ready    = 1'b1;
  assign rel_map_size = 64'd1 << MAP_SHIFT;
  assign idx  = req_addr[ADDR_W-1:OFS_W];
  assign off  = req_addr[OFS_W-1:0];
  assign size = acc_size_e'(req_size);
  assign cur  = tbl[idx];

  spin_lane_decode u_lanes (
    .off   (off),
    .size  (size),
    .wdata (req_wdata),
    .wen   (wen),
    .wbyte (wbyte)
  );

  spin_read_mux u_rmux (
    .ent   (cur),
    .off   (off),
    .size  (size),
    .rdata (rd_data),
    .bad   (rd_bad)
  );

  always_comb begin
    for (int b = 0; b < ENTRY_BYTES; b++) merged[b] = wen[b] ? wbyte[b] : cur[b];
    ent_addr = '0;
    ent_arg  = '0;
    for (int k = 0; k < 8; k++) begin
      ent_addr = {ent_addr[55:0], merged[ADDR_FIELD + k]};
      ent_arg  = {ent_arg[55:0],  merged[ARG_FIELD + k]};
    end
  end

  assign wr_ok   = req_valid && req_write && (size != SZ_BAD) &&
                   (idx != '0) && (32'(idx) < NUM_PRESENT);
  assign fire    = wr_ok && !ent_addr[0];
  assign rd_fire = req_valid && !req_write;
  assign pid_new = PID_BASE + 32'(idx);

  always_comb begin
    nxt = merged;
    if (fire) begin
      for (int k = 0; k < 4; k++) nxt[PID_FIELD + k] = pid_new[8*(3-k) +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < NUM_CORES; e++) begin
        tbl[e]                  <= '0;
        tbl[e][ADDR_FIELD + 7]  <= 8'd1;
        tbl[e][ARG_FIELD + 7]   <= 8'(e);
        tbl[e][PID_FIELD + 3]   <= 8'(e);
      end
    end else if (wr_ok) begin
      tbl[idx] <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= rd_fire;
      rsp_rdata <= rd_fire ? rd_data : '0;
      rsp_err   <= rd_fire && rd_bad;
    end
  end

  spin_release_gen #(
    .NUM_CORES (NUM_CORES),
    .MAP_SHIFT (MAP_SHIFT)
  ) u_rel (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .idx        (idx),
    .start_addr (ent_addr),
    .arg        (ent_arg),
    .pulse      (rel_pulse),
    .offset     (rel_offset),
    .base       (rel_base),
    .arg_o      (rel_arg)
  );
endmodule

// File: rtl/spin_table_chk.sv
module spin_table_chk #(
  parameter int NUM_CORES   = 32,
  parameter int NUM_PRESENT = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 req_write,
  input logic [1:0]           req_size,
  input logic                 rsp_valid,
  input logic                 rsp_err,
  input logic [NUM_CORES-1:0] rel_pulse,
  input logic [63:0]          rel_offset,
  input logic [63:0]          rel_base,
  input logic [63:0]          rel_arg
);
  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rel_pulse)); // R6
  AST_BOOT_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_pulse[0]); // R4
  AST_ABSENT_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_pulse >> NUM_PRESENT) == '0); // R5
  AST_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|rel_pulse) |-> $past(req_valid && req_write && req_size != 2'd3)); // R10
  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid); // R2
  AST_RSP_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write)); // R2
  AST_ERR_BAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && $past(req_size == 2'd3))); // R11
  AST_HOLD_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
    !(|rel_pulse) |-> ($stable(rel_base) && $stable(rel_offset) && $stable(rel_arg))); // R12
  AST_ALWAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready); // R12
endmodule

bind spin_table_ctrl spin_table_chk #(
  .NUM_CORES   (NUM_CORES),
  .NUM_PRESENT (NUM_PRESENT)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_size   (req_size),
  .rsp_valid  (rsp_valid),
  .rsp_err    (rsp_err),
  .rel_pulse  (rel_pulse),
  .rel_offset (rel_offset),
  .rel_base   (rel_base),
  .rel_arg    (rel_arg)
);

// File: tb/spin_table_ctrl_tb_top.sv
module spin_table_ctrl_tb_top;
  localparam int          NC = 32;
  localparam int          NP = 6;
  localparam logic [31:0] PB = 32'h0000_0100;
  localparam int          MS = 26;
  localparam int          AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [NC-1:0] rel_pulse;
  logic [63:0] rel_offset, rel_base, rel_arg, rel_map_size;

  always #5 clk = ~clk;

  spin_table_ctrl #(.NUM_CORES(NC), .NUM_PRESENT(NP), .PID_BASE(PB), .MAP_SHIFT(MS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .rel_pulse(rel_pulse), .rel_offset(rel_offset),
    .rel_base(rel_base), .rel_arg(rel_arg), .rel_map_size(rel_map_size)
  );

  logic [7:0] mdl [NC*32];
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [NC-1:0] exp_pulse = '0;
  logic [63:0] exp_off = '0, exp_base = '0, exp_arg = '0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int nbytes(logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [63:0] field64(int idx, int at);
    logic [63:0] v = '0;
    for (int k = 0; k < 8; k++) v = (v << 8) | 64'(mdl[idx*32 + at + k]);
    return v;
  endfunction

  function automatic logic [NC-1:0] model_write(int addr, logic [1:0] sz, logic [31:0] wd);
    int idx = addr / 32;
    int n, base;
    logic [63:0] a64, mask;
    logic [31:0] pid;
    if (sz == 2'd3 || idx == 0 || idx >= NP) return '0;
    n = nbytes(sz);
    base = addr - (addr % n);
    for (int k = 0; k < n; k++) mdl[base + k] = 8'(wd >> (8 * (n - 1 - k)));
    a64 = field64(idx, 0);
    if (a64[0]) return '0;
    mask = (64'd1 << MS) - 1;
    exp_off  = a64 & mask;
    exp_base = a64 & ~mask;
    exp_arg  = field64(idx, 8);
    pid = PB + 32'(idx);
    for (int k = 0; k < 4; k++) mdl[idx*32 + 20 + k] = 8'(pid >> (8 * (3 - k)));
    return NC'(1) << idx;
  endfunction

  function automatic logic [31:0] model_read(int addr, logic [1:0] sz);
    int n, base;
    logic [31:0] v = '0;
    if (sz == 2'd3) return '0;
    n = nbytes(sz);
    base = addr - (addr % n);
    for (int k = 0; k < n; k++) v = (v << 8) | 32'(mdl[base + k]);
    return v;
  endfunction

  // Per-cycle comparison of the release outputs against the model.
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R6", "rel_pulse", 64'(rel_pulse), 64'(exp_pulse));
      chk("R7", "rel_offset", rel_offset, exp_off);
      chk("R7", "rel_base", rel_base, exp_base);
      chk("R8", "rel_arg", rel_arg, exp_arg);
      chk("R7", "rel_map_size", rel_map_size, 64'd1 << MS);
      chk("R12", "req_ready", 64'(req_ready), 64'd1);
      exp_pulse = '0;
    end
  end

  task automatic access(string req, bit wr, int addr, logic [1:0] sz, logic [31:0] wd);
    logic [31:0] expd = '0;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = AW'(addr);
    req_size  = sz;
    req_wdata = wd;
    if (wr) exp_pulse = model_write(addr, sz, wd);
    else    expd = model_read(addr, sz);
    @(negedge clk);
    if (!wr) begin
      chk(req, "rsp_valid", 64'(rsp_valid), 64'd1);
      chk(req, "rsp_rdata", 64'(rsp_rdata), 64'(expd));
      chk(req, "rsp_err", 64'(rsp_err), 64'(sz == 2'd3));
    end else begin
      chk(req, "rsp_valid idle", 64'(rsp_valid), 64'd0);
    end
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < NC; e++) begin
      for (int b = 0; b < 32; b++) mdl[e*32 + b] = 8'h00;
      mdl[e*32 + 7]  = 8'd1;
      mdl[e*32 + 15] = 8'(e);
      mdl[e*32 + 23] = 8'(e);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R2", "rsp_valid reset", 64'(rsp_valid), 64'd0);
    // R1 reset contents, R2 read sizes
    access("R1", 0, 3*32 + 20, 2'd2, 0);
    access("R1", 0, 5*32 + 12, 2'd2, 0);
    access("R1", 0, 9*32 + 4,  2'd2, 0);
    access("R1", 0, 2*32 + 7,  2'd0, 0);
    access("R2", 0, 31*32 + 14, 2'd1, 0);
    access("R1", 0, 4*32 + 28, 2'd2, 0);
    // R3 placement and alignment
    access("R3", 1, 2*32 + 8,  2'd2, 32'h1122_3344);
    access("R3", 0, 2*32 + 8,  2'd0, 0);
    access("R3", 0, 2*32 + 9,  2'd0, 0);
    access("R3", 1, 2*32 + 13, 2'd1, 32'hABCD);
    access("R3", 0, 2*32 + 12, 2'd2, 0);
    access("R3", 1, 2*32 + 27, 2'd2, 32'hDEAD_BEEF);
    access("R3", 0, 2*32 + 24, 2'd2, 0);
    // R4 boot record, R5 absent record
    access("R4", 1, 0*32 + 4, 2'd2, 32'h0000_0000);
    access("R4", 0, 0*32 + 4, 2'd2, 0);
    access("R5", 1, 7*32 + 4, 2'd2, 32'h0000_0000);
    access("R5", 0, 7*32 + 4, 2'd2, 0);
    access("R5", 1, 31*32 + 7, 2'd0, 8'h00);
    access("R5", 0, 31*32 + 4, 2'd2, 0);
    // R6 R7 R8 R9 release of record 3
    access("R6", 1, 3*32 + 0, 2'd2, 32'h0000_0000);
    access("R6", 1, 3*32 + 4, 2'd2, 32'h0C34_5678);
    access("R9", 0, 3*32 + 20, 2'd2, 0);
    // R10 repeat and stop
    access("R10", 1, 3*32 + 15, 2'd0, 8'h77);
    access("R10", 1, 3*32 + 7,  2'd0, 8'h01);
    access("R10", 1, 3*32 + 15, 2'd0, 8'h55);
    access("R8", 0, 3*32 + 12, 2'd2, 0);
    // R7 high address word, record 5
    access("R7", 1, 5*32 + 0, 2'd2, 32'h0000_0002);
    access("R7", 1, 5*32 + 6, 2'd1, 32'hF000);
    access("R9", 0, 5*32 + 20, 2'd2, 0);
    // R11 invalid size
    access("R11", 0, 4*32 + 20, 2'd3, 0);
    access("R11", 1, 4*32 + 7,  2'd3, 32'h0000_0000);
    access("R11", 0, 4*32 + 4,  2'd2, 0);
    // R12 hold after idle cycles
    repeat (4) @(negedge clk);
    access("R1", 0, 1*32 + 20, 2'd2, 0);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule